// File: doc/BRIEF.md
# Supply Supervisor Reset and Watchdog Sequencer

This block is the digital control core of a supply supervisor. It takes synchronous flags for the supply level and the battery level, a watchdog kick line from the host processor, and a watchdog enable. It drives an active-low system reset and an active-low low-battery indication. The comparators, references, hysteresis and the timing capacitor are not part of this block. They are replaced by the input flags and by interval lengths given in clock ticks.

A single saturating tick counter times every interval. It counts the hold after power-up, then the watchdog monitoring window, then the short watchdog reset pulse. A sequencer selects which limit the counter is compared against and clears the counter at each phase change. While kicks stay away, the output repeats a full window with reset released followed by a short reset pulse. A falling supply always wins over the watchdog and forces reset. The low-battery output is a separate set/clear latch and does not interact with the reset logic.

With the default parameters the hold and the window are equal, and each is fifty times the pulse width. An integrator picks tick counts that suit the system clock.

Top module: `supv_reset_wdog`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, both `sys_rst_n` and `low_batt_n` are 0.
- R2: If `supply_lo` is 1 on a clock edge, `sys_rst_n` is 0 after that edge, whatever the watchdog state. It stays 0 for as long as `supply_lo` stays 1, and watchdog kicks have no effect during that time.
- R3: With `supply_lo` at 0, the hold interval starts on the first edge that sees `supply_ok_hi` at 1. `sys_rst_n` rises exactly HOLD_TICKS edges after that first edge. A supply that lies between the two thresholds (both flags 0) does not start the hold.
- R4: If `supply_lo` goes to 1 during the hold, the hold is abandoned and reset stays low. The next hold runs its full HOLD_TICKS length from zero.
- R5: A kick is a 1-to-0 transition of `wd_kick`. The input passes through a two-flop synchroniser, so the monitoring timer is cleared on the third edge after the input falls. A 0-to-1 transition does not clear the timer.
- R6: If no kick is seen for WIN_TICKS edges while reset is released, `sys_rst_n` goes to 0 for exactly PULSE_TICKS edges and then returns to 1.
- R7: While kicks stay absent, the output repeats a cycle of WIN_TICKS edges high followed by PULSE_TICKS edges low. Kicks spaced closer than WIN_TICKS keep `sys_rst_n` at 1 without a break.
- R8: While `wd_en` is 0, the watchdog never drives reset and its timer is held at zero. A full window of WIN_TICKS edges is counted from the first edge that sees `wd_en` at 1 again.
- R9: `low_batt_n` goes to 0 on the edge after `batt_lo` is 1. It goes back to 1 only on the edge after `batt_ok_hi` is 1 with `batt_lo` at 0. In all other cases it holds its value, independent of reset. On a falling supply it therefore reaches 0 before `sys_rst_n` does.
- R10: A kick falling edge that arrives during the power-on hold does not shorten or lengthen the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the logic |
| supply_ok_hi | input | 1 | Supply is above the upper reset threshold (synchronous) |
| supply_lo | input | 1 | Supply is below the lower reset threshold (synchronous) |
| batt_lo | input | 1 | Supply is below the lower battery threshold |
| batt_ok_hi | input | 1 | Supply is above the upper battery threshold |
| wd_kick | input | 1 | Watchdog service line, asynchronous; a falling edge is a kick |
| wd_en | input | 1 | 1 enables the watchdog, 0 holds its timer cleared |
| sys_rst_n | output | 1 | Active-low system reset |
| low_batt_n | output | 1 | Active-low low-battery indication |

## Verification
Both outputs are registered. A change on a supply or battery flag therefore shows up one edge after it is sampled. A kick falling edge needs two synchroniser edges plus one timer edge before it takes effect, so a timeout measured from an input fall ends WIN_TICKS+3 edges after the drive. The bench drives and samples on the falling clock edge. It counts edges in loops from the known start of each phase: the release after a hold, a pulse end, or the change of `wd_en`. It compares `sys_rst_n` on every tick against the expected window and pulse pattern, so a boundary that is off by one edge fails at that exact tick.

// File: rtl/supv_pkg.sv
package supv_pkg;

   // Sequencer phases of the supervisor
   typedef enum logic [1:0] {
      ST_UV    = 2'd0,   // supply low or not yet good: reset held
      ST_HOLD  = 2'd1,   // power-on hold counting, reset held
      ST_RUN   = 2'd2,   // reset released, watchdog monitoring
      ST_WDRST = 2'd3    // watchdog reset pulse
   } supv_state_e;

   // Interval the shared timebase is compared against
   typedef enum logic [1:0] {
      IV_NONE   = 2'd0,
      IV_HOLD   = 2'd1,
      IV_WINDOW = 2'd2,
      IV_PULSE  = 2'd3
   } supv_ival_e;

   function automatic int unsigned max3(input int unsigned a,
                                        input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/supv_kick_edge.sv
module supv_kick_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick_in,
   output logic kick_fall
);

   localparam int MSB = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("supv_kick_edge: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [MSB:0] sync_q;
   logic         last_q;

   // Idle level of the kick line is high; reset to that level so no
   // spurious fall is seen when reset is released.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         last_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[MSB-1:0], kick_in};
         last_q <= sync_q[MSB];
      end
   end

   assign kick_fall = last_q & ~sync_q[MSB];

   // R5: a single input fall yields a one-cycle event
   a_r5_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      kick_fall |=> !kick_fall);

endmodule

// File: rtl/supv_timebase.sv
module supv_timebase
   import supv_pkg::*;
#(
   parameter int HOLD_TICKS  = 5000,
   parameter int WIN_TICKS   = 5000,
   parameter int PULSE_TICKS = 100,
   parameter int CNT_W       = 13
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  supv_ival_e sel,
   output logic       expired
);

   localparam int unsigned LIM_MAX = max3(HOLD_TICKS, WIN_TICKS, PULSE_TICKS);
   localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_TICKS - 1);
   localparam logic [CNT_W-1:0] WIN_LAST   = CNT_W'(WIN_TICKS - 1);
   localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_TICKS - 1);
   localparam logic [CNT_W-1:0] BOUND      = CNT_W'(LIM_MAX - 1);

   generate
      if (HOLD_TICKS < 1 || WIN_TICKS < 1 || PULSE_TICKS < 1) begin : g_bad_len
         $error("supv_timebase: every interval needs at least one tick");
      end
      if ((2 ** CNT_W) <= LIM_MAX) begin : g_bad_width
         $error("supv_timebase: CNT_W too narrow for the longest interval");
      end
   endgenerate

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] last_tick;

   // Saturating tick counter, cleared by the sequencer at phase changes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (clear) begin
         count_q <= '0;
      end else if (count_q != {CNT_W{1'b1}}) begin
         count_q <= count_q + CNT_W'(1);
      end
   end

   always_comb begin
      unique case (sel)
         IV_HOLD:   last_tick = HOLD_LAST;
         IV_WINDOW: last_tick = WIN_LAST;
         IV_PULSE:  last_tick = PULSE_LAST;
         default:   last_tick = '0;
      endcase
   end

   assign expired = (sel != IV_NONE) && (count_q >= last_tick);

   // R6: the sequencer always restarts the count before it passes the
   // longest programmed interval
   a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= BOUND);

endmodule

// File: rtl/supv_batt_flag.sv
module supv_batt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic batt_lo,
   input  logic batt_ok_hi,
   output logic low_batt_n
);

   logic flag_q;

   // Set/clear latch: low threshold sets the indication, upper threshold
   // clears it, anything between keeps the previous value.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (batt_lo) begin
         flag_q <= 1'b0;
      end else if (batt_ok_hi) begin
         flag_q <= 1'b1;
      end
   end

   assign low_batt_n = flag_q;

   // R9: low level always signalled on the following edge
   a_r9_low_asserts: assert property (@(posedge clk) disable iff (!rst_n)
      batt_lo |=> !low_batt_n);

   // R9: between thresholds the output keeps its value
   a_r9_hysteresis_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!batt_lo && !batt_ok_hi) |=> $stable(low_batt_n));

endmodule

// File: rtl/supv_reset_wdog.sv
module supv_reset_wdog
   import supv_pkg::*;
#(
   parameter int HOLD_TICKS  = 5000,
   parameter int WIN_TICKS   = 5000,
   parameter int PULSE_TICKS = 100,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok_hi,
   input  logic supply_lo,
   input  logic batt_lo,
   input  logic batt_ok_hi,
   input  logic wd_kick,
   input  logic wd_en,
   output logic sys_rst_n,
   output logic low_batt_n
);

   localparam int unsigned LIM_MAX = max3(HOLD_TICKS, WIN_TICKS, PULSE_TICKS);
   localparam int          CNT_W   = $clog2(LIM_MAX + 1);

   generate
      if (PULSE_TICKS >= WIN_TICKS) begin : g_bad_ratio
         $error("supv_reset_wdog: reset pulse must be shorter than the window");
      end
   endgenerate

   supv_state_e state_q, state_nxt;
   supv_ival_e  ival_sel;
   logic        tb_clear;
   logic        tb_expired;
   logic        kick_fall;
   logic        rst_out_q;

   supv_kick_edge #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_kick (
      .clk       (clk),
      .rst_n     (rst_n),
      .kick_in   (wd_kick),
      .kick_fall (kick_fall)
   );

   supv_timebase #(
      .HOLD_TICKS  (HOLD_TICKS),
      .WIN_TICKS   (WIN_TICKS),
      .PULSE_TICKS (PULSE_TICKS),
      .CNT_W       (CNT_W)
   ) u_timebase (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (tb_clear),
      .sel     (ival_sel),
      .expired (tb_expired)
   );

   supv_batt_flag u_batt (
      .clk        (clk),
      .rst_n      (rst_n),
      .batt_lo    (batt_lo),
      .batt_ok_hi (batt_ok_hi),
      .low_batt_n (low_batt_n)
   );

   // Sequencer: chooses the interval and restarts the shared timebase
   always_comb begin
      state_nxt = state_q;
      tb_clear  = 1'b0;
      ival_sel  = IV_NONE;
      unique case (state_q)
         ST_UV: begin
            tb_clear = 1'b1;
            if (supply_ok_hi) state_nxt = ST_HOLD;
         end
         ST_HOLD: begin
            ival_sel = IV_HOLD;
            if (tb_expired) begin
               state_nxt = ST_RUN;
               tb_clear  = 1'b1;
            end
         end
         ST_RUN: begin
            ival_sel = IV_WINDOW;
            if (!wd_en || kick_fall) begin
               tb_clear = 1'b1;
            end else if (tb_expired) begin
               state_nxt = ST_WDRST;
               tb_clear  = 1'b1;
            end
         end
         ST_WDRST: begin
            ival_sel = IV_PULSE;
            if (tb_expired) begin
               state_nxt = ST_RUN;
               tb_clear  = 1'b1;
            end
         end
         default: begin
            state_nxt = ST_UV;
            tb_clear  = 1'b1;
         end
      endcase
      // Undervoltage has priority over every other condition
      if (supply_lo) begin
         state_nxt = ST_UV;
         tb_clear  = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_UV;
         rst_out_q <= 1'b0;
      end else begin
         state_q   <= state_nxt;
         rst_out_q <= (state_nxt == ST_RUN);
      end
   end

   assign sys_rst_n = rst_out_q;

   // R2: undervoltage forces reset on the next edge
   a_r2_uv_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
      supply_lo |=> !sys_rst_n);

   // R3: reset is only released out of the hold or out of a watchdog pulse
   a_r3_release_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_n) |-> ($past(state_q) == ST_HOLD || $past(state_q) == ST_WDRST));

   // R4: a supply drop during the hold abandons it
   a_r4_hold_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HOLD && supply_lo) |=> (state_q == ST_UV));

   // R8: a disabled watchdog never starts a reset pulse
   a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && !wd_en) |=> (state_q != ST_WDRST));

endmodule

// File: tb/test_supv_reset_wdog.sv
module test_supv_reset_wdog;

   localparam int HOLD  = 100;
   localparam int WIN   = 100;
   localparam int PULSE = 2;

   logic clk = 1'b0;
   logic rst_n;
   logic supply_ok_hi, supply_lo, batt_lo, batt_ok_hi, wd_kick, wd_en;
   logic sys_rst_n, low_batt_n;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   supv_reset_wdog #(
      .HOLD_TICKS  (HOLD),
      .WIN_TICKS   (WIN),
      .PULSE_TICKS (PULSE),
      .SYNC_STAGES (2)
   ) i_supv_reset_wdog (
      .clk          (clk),
      .rst_n        (rst_n),
      .supply_ok_hi (supply_ok_hi),
      .supply_lo    (supply_lo),
      .batt_lo      (batt_lo),
      .batt_ok_hi   (batt_ok_hi),
      .wd_kick      (wd_kick),
      .wd_en        (wd_en),
      .sys_rst_n    (sys_rst_n),
      .low_batt_n   (low_batt_n)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what,
                      input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s at %0t: actual=%b expected=%b", req, what, $time, act, exp);
      end
   endtask

   // Drive a good supply and follow the whole hold; kick_at > 0 adds a kick
   task automatic run_hold(input int kick_at, input string req);
      supply_lo    = 1'b0;
      supply_ok_hi = 1'b1;
      for (int i = 1; i <= HOLD + 1; i++) begin
         tick(1);
         chk(req, "hold reset", sys_rst_n, (i > HOLD) ? 1'b1 : 1'b0);
         if (kick_at > 0 && i == kick_at)     wd_kick = 1'b0;
         if (kick_at > 0 && i == kick_at + 4) wd_kick = 1'b1;
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      tick(3);
      chk("R1", "reset during rst_n", sys_rst_n, 1'b0);
      chk("R1", "battery during rst_n", low_batt_n, 1'b0);
      rst_n = 1'b1;
      tick(1);
      chk("R1", "reset after rst_n", sys_rst_n, 1'b0);
      chk("R1", "battery after rst_n", low_batt_n, 1'b0);
   endtask

   task automatic t_battery;
      batt_lo = 1'b0;
      tick(3);
      chk("R9", "between thresholds stays low", low_batt_n, 1'b0);
      batt_ok_hi = 1'b1;
      tick(1);
      chk("R9", "upper threshold clears", low_batt_n, 1'b1);
      chk("R9", "reset unaffected", sys_rst_n, 1'b0);
      batt_ok_hi = 1'b0;
      tick(3);
      chk("R9", "between thresholds stays high", low_batt_n, 1'b1);
   endtask

   task automatic t_wd_timeout;
      for (int i = 1; i <= 2 * (WIN + PULSE); i++) begin
         tick(1);
         chk((i <= WIN + PULSE) ? "R6" : "R7", "timeout pattern", sys_rst_n,
             ((i % (WIN + PULSE)) < WIN) ? 1'b1 : 1'b0);
      end
   endtask

   task automatic t_kick;
      for (int k = 0; k < 10; k++) begin
         wd_kick = 1'b0;
         for (int j = 1; j <= 40; j++) begin
            tick(1);
            if (j == 5) wd_kick = 1'b1;
            chk("R7", "regular kicks keep reset off", sys_rst_n, 1'b1);
         end
      end
      // Timing from a single input fall; its later rise must not clear
      wd_kick = 1'b0;
      for (int i = 1; i <= WIN + 3 + PULSE; i++) begin
         tick(1);
         if (i == 5) wd_kick = 1'b1;
         chk("R5", "timeout from falling edge", sys_rst_n,
             (i <= WIN + 2 || i >= WIN + 3 + PULSE) ? 1'b1 : 1'b0);
      end
   endtask

   task automatic t_wd_disable;
      wd_en = 1'b0;
      for (int i = 1; i <= 3 * WIN; i++) begin
         tick(1);
         chk("R8", "disabled watchdog silent", sys_rst_n, 1'b1);
      end
      wd_en = 1'b1;
      for (int i = 1; i <= WIN + PULSE; i++) begin
         tick(1);
         chk("R8", "full window after enable", sys_rst_n,
             (i < WIN || i >= WIN + PULSE) ? 1'b1 : 1'b0);
      end
   endtask

   task automatic t_undervoltage;
      batt_lo = 1'b1;
      tick(1);
      chk("R9", "battery low first", low_batt_n, 1'b0);
      chk("R9", "reset still released", sys_rst_n, 1'b1);
      supply_lo    = 1'b1;
      supply_ok_hi = 1'b0;
      tick(1);
      chk("R2", "undervoltage forces reset", sys_rst_n, 1'b0);
      for (int i = 1; i <= 3 * WIN; i++) begin
         tick(1);
         wd_kick = ((i / 10) % 2 == 0) ? 1'b0 : 1'b1;
         chk("R2", "reset held under undervoltage", sys_rst_n, 1'b0);
      end
      wd_kick = 1'b1;
      batt_lo = 1'b0;
      tick(2);
      chk("R9", "battery holds low without upper flag", low_batt_n, 1'b0);
   endtask

   task automatic t_hold_abort;
      supply_lo    = 1'b0;
      supply_ok_hi = 1'b1;
      for (int i = 1; i <= HOLD / 2; i++) begin
         tick(1);
         chk("R4", "first hold low", sys_rst_n, 1'b0);
      end
      supply_lo    = 1'b1;
      supply_ok_hi = 1'b0;
      tick(3);
      chk("R4", "drop during hold", sys_rst_n, 1'b0);
      supply_lo = 1'b0;
      for (int i = 1; i <= HOLD + 5; i++) begin
         tick(1);
         chk("R3", "between thresholds no hold", sys_rst_n, 1'b0);
      end
      run_hold(0, "R4");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run hung, actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n        = 1'b0;
      supply_ok_hi = 1'b0;
      supply_lo    = 1'b1;
      batt_lo      = 1'b1;
      batt_ok_hi   = 1'b0;
      wd_kick      = 1'b1;
      wd_en        = 1'b1;
      tick(1);
      t_reset();
      t_battery();
      run_hold(HOLD / 2, "R10");
      t_wd_timeout();
      t_kick();
      t_wd_disable();
      t_undervoltage();
      t_hold_abort();
      batt_ok_hi = 1'b1;
      tick(1);
      chk("R9", "battery recovers", low_batt_n, 1'b1);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule